// File: doc/BRIEF.md
# CSMA/CD Serial Transmit Controller

This block sends one Ethernet frame at a time as a single-bit NRZ stream, one bit per clock, with a transmit-enable output that is high for every bit it drives. After a start pulse it latches the byte count and waits until no carrier is sensed. It then sends a preamble of alternating ones and zeros and a two-bit start delimiter. Next come the frame bytes, pulled from a byte source over a valid/ready handshake, least significant bit first. A 32-bit frame check sequence closes the frame.

If the collision input is seen while the frame is on the line, the block stops the frame, drives a jam of ones and counts the collision. It then waits a random number of slot times and tries the same frame again from its first byte, so the byte source must replay the frame from the beginning whenever `tx_en` rises. The sixteenth collision ends the frame with an abort. When the byte source has nothing to offer at a byte boundary, the frame ends with an underrun. Each frame finishes with a one-cycle `done` pulse. At that pulse exactly one of the success and error results is set, and the status flags and the collision count stay stable until the next accepted start.

Back-pressure rules: `in_ready` is high only during the last bit of the preamble or of a byte, and only while bytes of the frame remain to be fetched. A byte moves on a rising clock edge with both `in_valid` and `in_ready` high. A cycle with `in_ready` high and `in_valid` low is an underrun, not a stall. `in_ready` never depends on `in_valid`.

Top module: `csma_tx_ctrl`

## Requirements
- R1: After an accepted start, `tx_en` rises only in the cycle after one where `carrier` was low. If `carrier` is high while the block waits before the first attempt, `st_deferred` is set for that frame.
- R2: Each attempt begins with 62 bits alternating 1,0 (starting with 1) followed by two 1 bits, so there are 64 bits before the first data bit, with `tx_en` high on every one of them.
- R3: Exactly `byte_count` bytes are taken from the source and sent least significant bit first, directly after the delimiter. A byte is taken on a clock edge with `in_valid` and `in_ready` both high, and `in_ready` is high only during the last bit before a byte is needed.
- R4: After the data come 32 bits of frame check sequence: the CRC-32 with reflected polynomial 0xEDB88320, preset to all ones, fed with the data bits in transmit order, then complemented and sent bit 0 first. With a byte count of zero, the frame is the 64 header bits followed by the check sequence.
- R5: A collision while the frame is on the line is followed by exactly 32 one bits of jam, after which `tx_en` falls. Each such collision adds one to `coll_count`.
- R6: After n collisions, the time from the fall of `tx_en` to its next rise is at most 2^min(n,10) slot times plus a few cycles. A slot is SLOT_BITS clocks.
- R7: The sixteenth collision ends the frame after its jam with `st_abort` and `tx_err` set and `coll_count` equal to 16. There is no further attempt.
- R8: A collision seen while bit index 512 or later of the attempt is on the line sets `st_late_coll`. Bit 0 is the first preamble bit. A collision at index 511 does not set it.
- R9: A cycle with `in_ready` high and `in_valid` low and no collision ends the frame: `tx_en` is low in the next cycle, and `st_underrun` and `tx_err` are set.
- R10: Every frame ends with a one-cycle `done` pulse while `tx_en` is low. Exactly one of `tx_ok` and `tx_err` is then high, and all results hold until the next accepted start.
- R11: If `carrier` was seen high during an attempt and later goes low while the frame is still on the line, `st_carrier_lost` is set. The frame still completes.
- R12: A start pulse while a frame is in progress is ignored. It neither changes the frame being sent nor causes another frame afterwards.
- R13: After reset, `tx_en`, `tx_data`, `in_ready`, `done`, `tx_ok`, `tx_err`, all status flags and `coll_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | One-cycle request to send a frame |
| byte_count | input | CNT_W | Number of frame bytes, sampled with start |
| in_data | input | 8 | Byte offered by the source |
| in_valid | input | 1 | Source has a byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| carrier | input | 1 | Carrier sensed on the medium |
| collision | input | 1 | Collision detected on the medium |
| tx_data | output | 1 | Serial NRZ line data |
| tx_en | output | 1 | Line driven this cycle |
| done | output | 1 | Frame finished (one cycle) |
| tx_ok | output | 1 | Frame sent successfully |
| tx_err | output | 1 | Frame ended in error |
| st_deferred | output | 1 | Carrier was present before the first attempt |
| st_carrier_lost | output | 1 | Carrier dropped during a transmission |
| st_late_coll | output | 1 | Collision after the 512-bit window |
| st_underrun | output | 1 | Source ran dry inside the frame |
| st_abort | output | 1 | Sixteen collisions |
| coll_count | output | clog2(MAX_COLL+1) | Collisions for this frame |

## Verification
The assertions assume that `start` is a pulse and that `collision` is only raised while the block is transmitting. They also assume that `carrier` echoes the block's own transmission, apart from deliberate early drops and a carrier held before the start. The underrun property further assumes that `in_valid`, like every input, is settled before the clock edge. The stimulus keeps to these rules. Its byte source model replays from byte zero on every rise of `tx_en` and stops offering data at a chosen index. Collisions are single-cycle pulses at a chosen bit index of a chosen number of attempts. The carrier follows `tx_en` except for a forced high stretch before the start and an optional drop at a given bit index.

// File: rtl/csma_tx_pkg.sv
package csma_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEFER,
    ST_PRE,
    ST_DATA,
    ST_FCS,
    ST_JAM,
    ST_WAIT
  } tx_state_e;

  typedef struct packed {
    logic deferred;
    logic carrier_lost;
    logic late_coll;
    logic underrun;
    logic abort;
  } tx_flags_t;

endpackage

// File: rtl/csma_crc32.sv
module csma_crc32 #(
  parameter logic [31:0] POLY = 32'hEDB88320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic upd,
  input  logic bit_in,
  input  logic shift,
  output logic fcs_bit
);

  logic [31:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (init) begin
      crc_q <= '1;
    end else if (upd) begin
      crc_q <= {1'b0, crc_q[31:1]} ^ ({32{crc_q[0] ^ bit_in}} & POLY);
    end else if (shift) begin
      crc_q <= {1'b1, crc_q[31:1]};
    end
  end

  // complemented remainder leaves bit 0 first
  assign fcs_bit = ~crc_q[0];

endmodule

// File: rtl/csma_backoff_rng.sv
module csma_backoff_rng #(
  parameter int          CAP    = 10,
  parameter int          ATT_W  = 5,
  parameter int          LFSR_W = 16,
  parameter logic [15:0] TAPS   = 16'hB400
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ATT_W-1:0] attempt,
  output logic [CAP-1:0]   slots
);

  logic [LFSR_W-1:0] lfsr_q;
  logic [CAP-1:0]    mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q <= '1;
    end else begin
      lfsr_q <= {1'b0, lfsr_q[LFSR_W-1:1]} ^ (lfsr_q[0] ? TAPS[LFSR_W-1:0] : '0);
    end
  end

  // window is 2^min(attempt,CAP) slots: bit i is open once attempt exceeds i
  for (genvar i = 0; i < CAP; i++) begin : g_mask
    assign mask[i] = int'(attempt) > i;
  end

  assign slots = lfsr_q[CAP-1:0] & mask;

endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl
  import csma_tx_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int PRE_BITS    = 62,   // even
  parameter int JAM_BITS    = 32,
  parameter int SLOT_BITS   = 512,
  parameter int WINDOW_BITS = 512,
  parameter int MAX_COLL    = 16,
  parameter int BACKOFF_CAP = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [CNT_W-1:0]              byte_count,
  input  logic [7:0]                    in_data,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          carrier,
  input  logic                          collision,
  output logic                          tx_data,
  output logic                          tx_en,
  output logic                          done,
  output logic                          tx_ok,
  output logic                          tx_err,
  output logic                          st_deferred,
  output logic                          st_carrier_lost,
  output logic                          st_late_coll,
  output logic                          st_underrun,
  output logic                          st_abort,
  output logic [$clog2(MAX_COLL+1)-1:0] coll_count
);

  localparam int COLL_W   = $clog2(MAX_COLL + 1);
  localparam int FCS_BITS = 32;
  localparam int HDR_LAST = PRE_BITS + 1;
  localparam int PH_MAX   = (HDR_LAST > JAM_BITS) ? HDR_LAST : JAM_BITS;
  localparam int PH_W     = $clog2(PH_MAX + FCS_BITS + 1);
  localparam int BITS_W   = $clog2(WINDOW_BITS + 1);
  localparam int SLOTC_W  = $clog2(SLOT_BITS + 1);

  tx_state_e              st;
  logic [PH_W-1:0]        phase;
  logic [2:0]             bitpos;
  logic [7:0]             shreg;
  logic [CNT_W-1:0]       len_q, left_q;
  logic [BITS_W-1:0]      bit_idx;
  logic [COLL_W-1:0]      coll_q;
  logic [BACKOFF_CAP-1:0] slots_q, slots_draw;
  logic [SLOTC_W-1:0]     slot_cyc;
  tx_flags_t              flags_q;
  logic                   done_q, ok_q, err_q, saw_crs;
  logic                   on_line, pre_last, byte_last, boundary;
  logic                   fcs_last, jam_last, late_now, fcs_bit;

  assign on_line   = (st == ST_PRE) || (st == ST_DATA) || (st == ST_FCS);
  assign pre_last  = (st == ST_PRE) && (phase == PH_W'(HDR_LAST));
  assign byte_last = (st == ST_DATA) && (bitpos == 3'd7);
  assign boundary  = pre_last || byte_last;
  assign fcs_last  = phase == PH_W'(FCS_BITS - 1);
  assign jam_last  = phase == PH_W'(JAM_BITS - 1);
  assign late_now  = bit_idx >= BITS_W'(WINDOW_BITS);

  assign in_ready = boundary && (left_q != '0);
  assign tx_en    = on_line || (st == ST_JAM);

  always_comb begin
    case (st)
      ST_PRE:  tx_data = ~phase[0] | pre_last;
      ST_DATA: tx_data = shreg[0];
      ST_FCS:  tx_data = fcs_bit;
      ST_JAM:  tx_data = 1'b1;
      default: tx_data = 1'b0;
    endcase
  end

  csma_crc32 u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (st == ST_DEFER),
    .upd     (st == ST_DATA),
    .bit_in  (shreg[0]),
    .shift   (st == ST_FCS),
    .fcs_bit (fcs_bit)
  );

  csma_backoff_rng #(
    .CAP   (BACKOFF_CAP),
    .ATT_W (COLL_W)
  ) u_rng (
    .clk     (clk),
    .rst_n   (rst_n),
    .attempt (coll_q),
    .slots   (slots_draw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      phase    <= '0;
      bitpos   <= '0;
      shreg    <= '0;
      len_q    <= '0;
      left_q   <= '0;
      bit_idx  <= '0;
      coll_q   <= '0;
      slots_q  <= '0;
      slot_cyc <= '0;
      flags_q  <= '0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
      err_q    <= 1'b0;
      saw_crs  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (on_line) begin
        if (!late_now) bit_idx <= bit_idx + 1'b1;
        if (carrier) saw_crs <= 1'b1;
        else if (saw_crs) flags_q.carrier_lost <= 1'b1;
      end
      case (st)
        ST_IDLE: begin
          if (start) begin
            len_q   <= byte_count;
            coll_q  <= '0;
            flags_q <= '0;
            ok_q    <= 1'b0;
            err_q   <= 1'b0;
            st      <= ST_DEFER;
          end
        end
        ST_DEFER: begin
          if (carrier) begin
            if (coll_q == '0) flags_q.deferred <= 1'b1;
          end else begin
            st      <= ST_PRE;
            phase   <= '0;
            bit_idx <= '0;
            saw_crs <= 1'b0;
            left_q  <= len_q;
          end
        end
        ST_PRE, ST_DATA, ST_FCS: begin
          if (collision) begin
            coll_q <= coll_q + 1'b1;
            if (late_now) flags_q.late_coll <= 1'b1;
            st    <= ST_JAM;
            phase <= '0;
          end else if (boundary) begin
            if (left_q == '0) begin
              st    <= ST_FCS;
              phase <= '0;
            end else if (in_valid) begin
              shreg  <= in_data;
              left_q <= left_q - 1'b1;
              bitpos <= '0;
              st     <= ST_DATA;
            end else begin
              flags_q.underrun <= 1'b1;
              err_q  <= 1'b1;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end
          end else if (st == ST_PRE) begin
            phase <= phase + 1'b1;
          end else if (st == ST_DATA) begin
            bitpos <= bitpos + 1'b1;
            shreg  <= {1'b0, shreg[7:1]};
          end else begin
            phase <= phase + 1'b1;
            if (fcs_last) begin
              ok_q   <= 1'b1;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end
          end
        end
        ST_JAM: begin
          phase <= phase + 1'b1;
          if (jam_last) begin
            if (coll_q == COLL_W'(MAX_COLL)) begin
              flags_q.abort <= 1'b1;
              err_q  <= 1'b1;
              done_q <= 1'b1;
              st     <= ST_IDLE;
            end else begin
              slots_q  <= slots_draw;
              slot_cyc <= '0;
              st       <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (slots_q == '0) begin
            st <= ST_DEFER;
          end else if (slot_cyc == SLOTC_W'(SLOT_BITS - 1)) begin
            slot_cyc <= '0;
            slots_q  <= slots_q - 1'b1;
          end else begin
            slot_cyc <= slot_cyc + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done            = done_q;
  assign tx_ok           = ok_q;
  assign tx_err          = err_q;
  assign st_deferred     = flags_q.deferred;
  assign st_carrier_lost = flags_q.carrier_lost;
  assign st_late_coll    = flags_q.late_coll;
  assign st_underrun     = flags_q.underrun;
  assign st_abort        = flags_q.abort;
  assign coll_count      = coll_q;

endmodule

// File: rtl/csma_tx_chk.sv
module csma_tx_chk #(
  parameter int COLL_W   = 5,
  parameter int MAX_COLL = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              carrier,
  input logic              collision,
  input logic              in_valid,
  input logic              in_ready,
  input logic              tx_en,
  input logic              done,
  input logic              tx_ok,
  input logic              tx_err,
  input logic              st_abort,
  input logic [COLL_W-1:0] coll_count
);

  AST_START_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> !$past(carrier)); // R1

  AST_READY_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_en); // R3

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tx_ok != tx_err)); // R10

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !tx_en); // R10

  AST_ABORT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && st_abort) |-> (int'(coll_count) == MAX_COLL)); // R7

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(coll_count) <= MAX_COLL); // R7

  AST_UNDERRUN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid && !collision) |=> !tx_en); // R9

endmodule

bind csma_tx_ctrl csma_tx_chk #(
  .COLL_W   (COLL_W),
  .MAX_COLL (MAX_COLL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .carrier    (carrier),
  .collision  (collision),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .tx_en      (tx_en),
  .done       (done),
  .tx_ok      (tx_ok),
  .tx_err     (tx_err),
  .st_abort   (st_abort),
  .coll_count (coll_count)
);

// File: tb/sim_csma_tx_ctrl.sv
module sim_csma_tx_ctrl;

  localparam int CNT_W  = 11;
  localparam int SLOT   = 4;
  localparam int COLL_W = 5;
  localparam int NV     = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [CNT_W-1:0]  byte_count = '0;
  logic [7:0]        in_data = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              carrier = 1'b0;
  logic              collision = 1'b0;
  logic              tx_data, tx_en, done, tx_ok, tx_err;
  logic              st_deferred, st_carrier_lost, st_late_coll, st_underrun, st_abort;
  logic [COLL_W-1:0] coll_count;

  csma_tx_ctrl #(.CNT_W(CNT_W), .SLOT_BITS(SLOT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .carrier(carrier), .collision(collision), .tx_data(tx_data), .tx_en(tx_en),
    .done(done), .tx_ok(tx_ok), .tx_err(tx_err), .st_deferred(st_deferred),
    .st_carrier_lost(st_carrier_lost), .st_late_coll(st_late_coll),
    .st_underrun(st_underrun), .st_abort(st_abort), .coll_count(coll_count)
  );

  // e_flags = {abort, late, underrun, deferred, carrier_lost}
  typedef struct packed {
    logic [7:0]  len;
    logic [11:0] coll_at;
    logic [4:0]  ncoll;
    logic [7:0]  under;
    logic [7:0]  defer;
    logic [11:0] drop;
    logic        e_ok;
    logic [4:0]  e_flags;
    logic [4:0]  e_cnt;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'd0,  12'hFFF, 5'd0,  8'hFF, 8'd0,  12'hFFF, 1'b1, 5'b00000, 5'd0},
    '{8'd5,  12'hFFF, 5'd0,  8'hFF, 8'd0,  12'hFFF, 1'b1, 5'b00000, 5'd0},
    '{8'd20, 12'hFFF, 5'd0,  8'hFF, 8'd20, 12'hFFF, 1'b1, 5'b00010, 5'd0},
    '{8'd20, 12'd30,  5'd1,  8'hFF, 8'd0,  12'hFFF, 1'b1, 5'b00000, 5'd1},
    '{8'd70, 12'd511, 5'd1,  8'hFF, 8'd0,  12'hFFF, 1'b1, 5'b00000, 5'd1},
    '{8'd70, 12'd512, 5'd1,  8'hFF, 8'd0,  12'hFFF, 1'b1, 5'b01000, 5'd1},
    '{8'd10, 12'hFFF, 5'd0,  8'd3,  8'd0,  12'hFFF, 1'b0, 5'b00100, 5'd0},
    '{8'd20, 12'd10,  5'd16, 8'hFF, 8'd0,  12'hFFF, 1'b0, 5'b10000, 5'd16},
    '{8'd20, 12'd40,  5'd3,  8'hFF, 8'd0,  12'hFFF, 1'b1, 5'b00000, 5'd3},
    '{8'd30, 12'hFFF, 5'd0,  8'hFF, 8'd0,  12'd200, 1'b1, 5'b00001, 5'd0}
  };

  int n_chk = 0;
  int n_fail = 0;

  // monitor / source model state
  int cfg_vec = 0, cfg_coll_at = 4095, cfg_ncoll = 0, cfg_under = 255, cfg_drop = 4095;
  int defer_left = 0;
  int m_cnt = 0, m_idx = 0, m_rises = 0, m_len = 0, gap = 0, gap_bad = 0;
  int first_len = 0, r1_viol = 0;
  bit m_took = 1'b0, m_prev_en = 1'b0, first_jam = 1'b0;
  bit bits [0:1023];
  bit exp_bits [0:1023];
  int exp_n = 0;

  function automatic logic [7:0] byte_at(int vid, int i);
    return 8'((i * 37 + vid * 11 + 5) & 255);
  endfunction

  function automatic int gap_bound(int n);
    int k = (n > 10) ? 10 : n;
    return (1 << k) * SLOT + 4;
  endfunction

  task automatic build_exp(input int vid, input int len);
    logic [31:0] crc = '1;
    logic b;
    exp_n = 0;
    for (int p = 0; p < 64; p++) begin
      exp_bits[exp_n] = (p < 62) ? (p % 2 == 0) : 1'b1;
      exp_n++;
    end
    for (int i = 0; i < len; i++) begin
      for (int k = 0; k < 8; k++) begin
        b = byte_at(vid, i)[k];
        exp_bits[exp_n] = b;
        exp_n++;
        crc = {1'b0, crc[31:1]} ^ ((crc[0] ^ b) ? 32'hEDB88320 : 32'h0);
      end
    end
    for (int k = 0; k < 32; k++) begin
      exp_bits[exp_n] = ~crc[k];
      exp_n++;
    end
  endtask

  task automatic chk(input bit cond, input string req, input int act, input int expv);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // source, medium and line monitor, all acting at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (m_took) m_idx++;
      m_took = 1'b0;
      if (tx_en) begin
        if (!m_prev_en) begin
          m_rises++;
          m_cnt = 0;
          m_idx = 0;
          if (defer_left > 0) r1_viol++;
          if (m_rises > 1 && gap > gap_bound(m_rises - 1)) gap_bad++;
        end else begin
          m_cnt++;
        end
        if (m_cnt < 1024) bits[m_cnt] = tx_data;
        m_len = m_cnt + 1;
      end else begin
        if (m_prev_en) begin
          gap = 0;
          if (m_rises == 1) begin
            first_len = m_len;
            first_jam = (m_len >= 32);
            for (int j = m_len - 32; j < m_len; j++)
              if (j >= 0 && !bits[j]) first_jam = 1'b0;
          end
        end
        gap++;
      end
      in_valid  = (m_idx < cfg_under);
      in_data   = byte_at(cfg_vec, m_idx);
      m_took    = in_ready && in_valid;
      collision = tx_en && (m_rises - 1 < cfg_ncoll) && (m_cnt == cfg_coll_at);
      if (defer_left > 0) begin
        carrier = 1'b1;
        defer_left--;
      end else begin
        carrier = tx_en && !(m_cnt >= cfg_drop);
      end
      m_prev_en = tx_en;
    end
  end

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int k = 0; k < 60000; k++) begin
      @(negedge clk);
      if (done) begin
        got = 1'b1;
        return;
      end
    end
  endtask

  task automatic setup(input int vid, input int coll_at, input int ncoll,
                       input int under, input int dfr, input int drop);
    @(posedge clk);
    cfg_vec = vid; cfg_coll_at = coll_at; cfg_ncoll = ncoll;
    cfg_under = under; cfg_drop = drop; defer_left = dfr;
    m_rises = 0; gap_bad = 0; first_len = 0; first_jam = 1'b0; r1_viol = 0;
  endtask

  task automatic run_vec(input int i);
    vec_t v = VECS[i];
    bit got;
    int mism;
    logic [5:0] snap;
    setup(i, int'(v.coll_at), int'(v.ncoll), int'(v.under), int'(v.defer), int'(v.drop));
    @(negedge clk);
    byte_count = CNT_W'(v.len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    chk(got, "R10 done seen", int'(got), 1);
    chk(tx_ok == v.e_ok && tx_err == !v.e_ok, "R10 result", int'({tx_ok, tx_err}), int'({v.e_ok, !v.e_ok}));
    chk({st_abort, st_late_coll, st_underrun, st_deferred, st_carrier_lost} == v.e_flags,
        "R1 R7 R8 R9 R11 flags",
        int'({st_abort, st_late_coll, st_underrun, st_deferred, st_carrier_lost}), int'(v.e_flags));
    chk(coll_count == v.e_cnt, "R5 R7 collision count", int'(coll_count), int'(v.e_cnt));
    chk(r1_viol == 0, "R1 no start under carrier", r1_viol, 0);
    if (v.e_ok) begin
      build_exp(i, int'(v.len));
      mism = 0;
      for (int p = 0; p < 64; p++) if (bits[p] != exp_bits[p]) mism++;
      chk(mism == 0, "R2 preamble bits", mism, 0);
      mism = 0;
      for (int p = 64; p < exp_n; p++) if (bits[p] != exp_bits[p]) mism++;
      chk(mism == 0 && m_len == exp_n, "R3 R4 data and check bits", m_len, exp_n);
    end
    if (v.e_flags[2])
      chk(m_len == 64 + 8 * int'(v.under), "R9 line stops at underrun", m_len, 64 + 8 * int'(v.under));
    if (v.ncoll != 0) begin
      chk(first_len == int'(v.coll_at) + 33 && first_jam, "R5 jam length",
          first_len, int'(v.coll_at) + 33);
      chk(gap_bad == 0, "R6 backoff bound", gap_bad, 0);
    end
    snap = {tx_ok, tx_err, st_abort, st_late_coll, st_underrun, st_carrier_lost};
    repeat (3) @(negedge clk);
    chk(snap == {tx_ok, tx_err, st_abort, st_late_coll, st_underrun, st_carrier_lost},
        "R10 results held", int'({tx_ok, tx_err, st_abort, st_late_coll, st_underrun, st_carrier_lost}),
        int'(snap));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit got;
    int mism;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk({tx_en, tx_data, in_ready, done, tx_ok, tx_err} == 6'b0, "R13 reset outputs",
        int'({tx_en, tx_data, in_ready, done, tx_ok, tx_err}), 0);
    chk({st_deferred, st_carrier_lost, st_late_coll, st_underrun, st_abort} == 5'b0 && coll_count == '0,
        "R13 reset status", int'(coll_count), 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R12: second start during a frame is ignored
    setup(10, 4095, 0, 255, 0, 4095);
    @(negedge clk);
    byte_count = CNT_W'(5);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    byte_count = CNT_W'(50);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(got);
    build_exp(10, 5);
    mism = 0;
    for (int p = 0; p < exp_n; p++) if (bits[p] != exp_bits[p]) mism++;
    chk(got && tx_ok && mism == 0 && m_len == exp_n, "R12 frame unchanged", m_len, exp_n);
    repeat (300) @(negedge clk);
    chk(m_rises == 1, "R12 no extra frame", m_rises, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule